// File: doc/BRIEF.md
# Receive Buffer Interrupt Vector Generator

This block watches a bank of receive message buffers, each of which carries an interrupt flag and an interrupt enable. It reports which buffer the host should service first: the lowest-numbered buffer whose flag and enable are both set. The result is a read-only 16-bit register that holds the buffer index. The block also drives a summary receive-interrupt status bit that tells the host whether the index is meaningful.

The flag and enable vectors are sampled on a microtick strobe. The register takes the encoded result on the next strobe, so any flag change shows up one microtick after it is sampled. While the controller is in its configuration state, and on any hard reset, the register and the status bit are held at zero.

Index 0 is a legal winner. The register therefore reads zero both when buffer 0 wins and when nothing is pending. The host has to look at the status bit to tell these two cases apart.

Top module: `rxvec_gen`

## Requirements
- R1: When more than one buffer has both its flag and its enable set, the register reports the smallest such index.
- R2: A buffer whose flag is set but whose enable is clear is never reported, and it does not raise the status bit.
- R3: There are 59 buffers, indexed 0 to 58. The index sits in register bits 5:0, and bits 15:6 always read 0.
- R4: When no buffer has both its flag and its enable set, the register reads 0x0000 and the status bit is 0.
- R5: The status bit is 1 exactly when at least one buffer had both its flag and its enable set in the sample that produced the current index.
- R6: An active-low hard reset clears the register and the status bit at once.
- R7: While the configuration-state input is high, the register reads 0 and the status bit is 0. After that input falls, both stay 0 until the second strobe.
- R8: Flags and enables are sampled on a strobe. The register and the status bit load that sample on the next strobe. On cycles without a strobe, the outputs do not change.
- R9: When buffer 0 wins, the register reads 0x0000 and the status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous hard reset, active low |
| cfg_mode_i | input | 1 | High while the controller is in its configuration state |
| utick_i | input | 1 | Microtick strobe, one clock cycle wide |
| irq_flag_i | input | 59 | Per-buffer interrupt flags |
| irq_ena_i | input | 59 | Per-buffer interrupt enables |
| vec_reg_o | output | 16 | Host-readable vector register; index in bits 5:0 |
| rx_irq_o | output | 1 | Summary receive-interrupt status; qualifies the vector |

## Verification
The assertions make three assumptions about the inputs:
- Reset is asserted from time zero.
- The strobe and the configuration-state input are synchronous to the clock.
- The flag and enable inputs carry no X values.

The bench keeps within these limits. It drives every input at the falling clock edge and raises the strobe for a single cycle. It changes flags and enables only between strobes, so each check can count exactly two strobes from a stimulus to the output that reflects it.

// File: rtl/rxvec_pkg.sv
package rxvec_pkg;

    // Default bank geometry and register width
    parameter int unsigned DEF_NUM_BUF = 59;
    parameter int unsigned DEF_REG_W   = 16;

    // Width needed to hold any index of a bank of n entries
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Number of positions after padding up to a power of two
    function automatic int unsigned pad_width(input int unsigned n);
        return 1 << idx_width(n);
    endfunction

endpackage

// File: rtl/rxvec_mask.sv
module rxvec_mask #(
    parameter int unsigned NUM_BUF = rxvec_pkg::DEF_NUM_BUF,
    parameter int unsigned PAD_W   = rxvec_pkg::pad_width(NUM_BUF)
) (
    input  logic [NUM_BUF-1:0] flag_i,
    input  logic [NUM_BUF-1:0] ena_i,
    output logic [PAD_W-1:0]   pend_o
);

    // Live buffers: pending when flag and enable are both set
    for (genvar g = 0; g < PAD_W; g++) begin : g_pos
        if (g < NUM_BUF) begin : g_live
            assign pend_o[g] = flag_i[g] & ena_i[g];
        end else begin : g_tie
            // Padding positions can never be selected
            assign pend_o[g] = 1'b0;
        end
    end

endmodule

// File: rtl/rxvec_prio_enc.sv
module rxvec_prio_enc #(
    parameter int unsigned PAD_W = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic [PAD_W-1:0] pend_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    // Lowest set position wins: scan from the top so lower indices overwrite
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = PAD_W - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
    end

    // R1: the chosen position is set and nothing below it is set
    always_comb begin
        if (any_o) begin
            assert_sel_is_set_R1: assert (pend_i[idx_o])
                else $error("selected index not pending");
            assert_sel_is_lowest_R1: assert ((pend_i & ((PAD_W'(1) << idx_o) - PAD_W'(1))) == '0)
                else $error("lower pending index skipped");
        end else begin
            assert_none_idle_R4: assert (pend_i == '0)
                else $error("pending bit missed");
        end
    end

endmodule

// File: rtl/rxvec_regfmt.sv
module rxvec_regfmt #(
    parameter int unsigned IDX_W = 6,
    parameter int unsigned REG_W = rxvec_pkg::DEF_REG_W
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [REG_W-1:0] reg_o
);

    // Index in the low bits, reserved bits read as zero
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b < IDX_W) begin : g_idx
            assign reg_o[b] = idx_i[b];
        end else begin : g_rsvd
            assign reg_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/rxvec_gen.sv
module rxvec_gen #(
    parameter int unsigned NUM_BUF = rxvec_pkg::DEF_NUM_BUF,
    parameter int unsigned REG_W   = rxvec_pkg::DEF_REG_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_mode_i,
    input  logic               utick_i,
    input  logic [NUM_BUF-1:0] irq_flag_i,
    input  logic [NUM_BUF-1:0] irq_ena_i,
    output logic [REG_W-1:0]   vec_reg_o,
    output logic               rx_irq_o
);

    localparam int unsigned IDX_W = rxvec_pkg::idx_width(NUM_BUF);
    localparam int unsigned PAD_W = rxvec_pkg::pad_width(NUM_BUF);

    // Complete registered state of the block
    typedef struct packed {
        logic [PAD_W-1:0] pend;   // sample taken on the last strobe
        logic [IDX_W-1:0] vec;    // published index
        logic             stat;   // published summary status
    } st_t;

    st_t st_d, st_q;

    logic [PAD_W-1:0] pend_live;
    logic [IDX_W-1:0] enc_idx;
    logic             enc_any;

    rxvec_mask #(
        .NUM_BUF (NUM_BUF),
        .PAD_W   (PAD_W)
    ) u_mask (
        .flag_i  (irq_flag_i),
        .ena_i   (irq_ena_i),
        .pend_o  (pend_live)
    );

    // The encoder works on the stored sample: one strobe of latency
    rxvec_prio_enc #(
        .PAD_W  (PAD_W),
        .IDX_W  (IDX_W)
    ) u_enc (
        .pend_i (st_q.pend),
        .idx_o  (enc_idx),
        .any_o  (enc_any)
    );

    rxvec_regfmt #(
        .IDX_W  (IDX_W),
        .REG_W  (REG_W)
    ) u_fmt (
        .idx_i  (st_q.vec),
        .reg_o  (vec_reg_o)
    );

    assign rx_irq_o = st_q.stat;

    always_comb begin
        st_d = st_q;
        if (cfg_mode_i) begin
            // Configuration state: everything held at zero
            st_d = '0;
        end else if (utick_i) begin
            st_d.pend = pend_live;
            st_d.vec  = enc_any ? enc_idx : '0;
            st_d.stat = enc_any;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: configuration state forces zero output on the next cycle
    assert_cfg_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_mode_i |=> (vec_reg_o == '0) && !rx_irq_o)
        else $error("configuration state did not clear register");

    // R4: without status the vector must read zero
    assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_irq_o |-> (vec_reg_o == '0))
        else $error("vector nonzero while status low");

    // R8: outputs only move on a strobe or configuration entry
    assert_hold_no_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!utick_i && !cfg_mode_i) |=> ($stable(vec_reg_o) && $stable(rx_irq_o)))
        else $error("output changed without strobe");

    // R3: reported index never exceeds the last buffer
    assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_irq_o |-> (vec_reg_o < REG_W'(NUM_BUF)))
        else $error("index out of range");

    // R5: a status rise needs a strobe in the previous cycle
    assert_stat_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rx_irq_o) |-> $past(utick_i))
        else $error("status rose without strobe");

endmodule

// File: tb/rxvec_gen_bench.sv
`timescale 1ns/1ps
module rxvec_gen_bench;

    localparam int NB = 59;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg = 1'b0;
    logic          tick = 1'b0;
    logic [NB-1:0] flg = '0;
    logic [NB-1:0] ena = '0;
    logic [15:0]   vreg;
    logic          stat;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rxvec_gen u_rxvec_gen (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cfg_mode_i (cfg),
        .utick_i    (tick),
        .irq_flag_i (flg),
        .irq_ena_i  (ena),
        .vec_reg_o  (vreg),
        .rx_irq_o   (stat)
    );

    // Model: lowest index with flag and enable both set, -1 when none
    function automatic int low_idx(input logic [NB-1:0] f, input logic [NB-1:0] e);
        for (int i = 0; i < NB; i++)
            if (f[i] && e[i]) return i;
        return -1;
    endfunction

    task automatic check(input string req, input logic [15:0] ev, input logic es);
        n_run++;
        if (vreg !== ev || stat !== es) begin
            n_fail++;
            $display("FAIL %s: reg=%h stat=%b expected reg=%h stat=%b", req, vreg, stat, ev, es);
        end
    endtask

    task automatic check_model(input string req);
        int w;
        w = low_idx(flg, ena);
        check(req, (w < 0) ? 16'h0000 : 16'(w), (w >= 0));
    endtask

    // One-cycle strobe; returns at the falling edge after the loading edge
    task automatic strobe();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic apply(input logic [NB-1:0] f, input logic [NB-1:0] e);
        @(negedge clk);
        flg = f;
        ena = e;
        strobe();
        strobe();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [NB-1:0] f;
        logic [63:0]   lfsr;
        repeat (3) @(negedge clk);
        // R6: reset state
        check("R6 reset", 16'h0000, 1'b0);
        rst_n = 1'b1;
        strobe();
        strobe();
        check("R4 idle after reset", 16'h0000, 1'b0);

        // R3/R9: every single index, including buffer 0 and 58
        for (int i = 0; i < NB; i++) begin
            apply(NB'(1) << i, '1);
            check(i == 0 ? "R9 buffer0 wins" : "R3 single index", 16'(i), 1'b1);
        end

        // R1: every pair of set flags
        for (int i = 0; i < NB; i++)
            for (int j = 0; j < NB; j++) begin
                apply((NB'(1) << i) | (NB'(1) << j), '1);
                check_model("R1 pair");
            end

        // R2: all flags, single enable; flags without enable
        for (int k = 0; k < NB; k++) begin
            apply('1, NB'(1) << k);
            check("R2 single enable", 16'(k), 1'b1);
        end
        apply('1, '0);
        check("R2 no enable", 16'h0000, 1'b0);
        apply('0, '1);
        check("R4 no flag", 16'h0000, 1'b0);

        // R5: pseudo-random patterns
        lfsr = 64'h1234_5678_9abc_def1;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            f = lfsr[NB-1:0];
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            apply(f, lfsr[NB-1:0] & {lfsr[30:0], lfsr[63:36]});
            check_model("R5 random");
        end

        // R8: latency of one strobe, hold without strobe
        apply(NB'(1) << 20, '1);
        @(negedge clk) flg = NB'(1) << 7;
        repeat (4) @(negedge clk);
        check("R8 hold without strobe", 16'd20, 1'b1);
        strobe();
        check("R8 first strobe samples only", 16'd20, 1'b1);
        strobe();
        check("R8 second strobe loads", 16'd7, 1'b1);

        // R7: configuration state
        @(negedge clk) cfg = 1'b1;
        @(negedge clk);
        check("R7 cfg clears", 16'h0000, 1'b0);
        strobe();
        check("R7 cfg holds on strobe", 16'h0000, 1'b0);
        @(negedge clk) cfg = 1'b0;
        check("R7 leaving cfg zero", 16'h0000, 1'b0);
        strobe();
        check("R7 one strobe after cfg", 16'h0000, 1'b0);
        strobe();
        check("R7 second strobe after cfg", 16'd7, 1'b1);

        // R6: asynchronous hard reset mid-run
        @(negedge clk) rst_n = 1'b0;
        #1;
        check("R6 async reset", 16'h0000, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        strobe();
        check("R6 one strobe after reset", 16'h0000, 1'b0);
        strobe();
        check("R6 reload after reset", 16'd7, 1'b1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule